// File: doc/BRIEF.md
# Condition-Code Floating Operand Select

This unit chooses between two floating-point register operands and writes the chosen value back, with no arithmetic. The choice is made by a 2-bit condition code tested against the integer N, Z and V flags. A request carries the two operands, a precision flag, the condition code, the flags and three register indices: destination, first source and second source. One cycle later the unit presents the result, the destination index and a write strobe.

Two build-time options set how legal a request is. One says whether the select operation exists at all. The other says whether the double-precision register bank has 32 entries or only 16. A request that the configuration cannot execute raises an undefined-operation pulse instead of a write. Single-precision requests return the low 32 bits of the chosen operand, with the upper result bits cleared.

Top module: `fp_cond_select`

## Requirements
- R1: After reset, wrEn and undefFlag are low and resData is zero.
- R2: Condition code 0 (equal) selects opN when flagZ is 1; otherwise it selects opM.
- R3: Condition code 1 (overflow) selects opN when flagV is 1; otherwise it selects opM.
- R4: Condition code 2 (greater or equal) selects opN when flagN equals flagV; otherwise it selects opM.
- R5: Condition code 3 (greater than) selects opN only when flagZ is 0 and flagN equals flagV; otherwise it selects opM.
- R6: When isDouble is 0, resData[31:0] is bits 31:0 of the chosen operand and resData[63:32] is zero. When isDouble is 1, all 64 bits of the chosen operand are returned.
- R7: When HAS_UPPER_BANK is 0 and isDouble is 1, a request in which bit 4 of idxD, idxN or idxM is set raises undefFlag. It gives no wrEn pulse, and resData and wrIdx keep their previous values.
- R8: A single-precision request never raises undefFlag because of bit 4 of an index when the select feature is present.
- R9: When HAS_UPPER_BANK is 1, double-precision requests with bit 4 set in any index complete normally.
- R10: When HAS_SEL is 0, every request raises undefFlag and none writes.
- R11: wrEn and undefFlag are one-cycle pulses in the cycle after a request with reqValid high. Without a request both stay low and resData holds its value.
- R12: On a write, wrIdx equals the idxD of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present this cycle |
| isDouble | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| condCode | input | 2 | 0 eq, 1 vs, 2 ge, 3 gt |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| idxD | input | 5 | Destination register index |
| idxN | input | 5 | First source register index |
| idxM | input | 5 | Second source register index |
| opN | input | 64 | First operand (taken when the condition holds) |
| opM | input | 64 | Second operand |
| resData | output | 64 | Selected result |
| wrIdx | output | 5 | Destination index of the result |
| wrEn | output | 1 | Write strobe |
| undefFlag | output | 1 | Undefined-operation pulse |

## Verification
The bench builds three copies of the unit. The default copy (select present, 16-entry double bank) covers the index-bit rejection in R7 and shows that single-precision requests are exempt. A copy with HAS_UPPER_BANK=1 receives the same requests and must complete the high-index double requests that the default copy rejects. A copy with HAS_SEL=0 must reject everything. Feeding all three copies the same stimulus checks every flag combination under each condition code against all three legality outcomes.

// File: rtl/fcsel_pkg.sv
package fcsel_pkg;

  typedef enum logic [1:0] {
    CC_EQUAL   = 2'd0,
    CC_OVFL    = 2'd1,
    CC_GEQ     = 2'd2,
    CC_GREATER = 2'd3
  } cond_e;

  typedef struct packed {
    logic load;
    logic pickFirst;
    logic narrow;
  } sel_strobe_t;

endpackage

// File: rtl/fcsel_ctrl.sv
module fcsel_ctrl
  import fcsel_pkg::*;
#(
  parameter int IDX_W          = 5,
  parameter bit HAS_SEL        = 1'b1,
  parameter bit HAS_UPPER_BANK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             isDouble,
  input  logic [1:0]       condCode,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagV,
  input  logic [IDX_W-1:0] idxD,
  input  logic [IDX_W-1:0] idxN,
  input  logic [IDX_W-1:0] idxM,
  output sel_strobe_t      strobe,
  output logic             undefFlag
);

  localparam int BANK_BIT = IDX_W - 1;

  cond_e cond;
  logic  condMet;
  logic  highIdx;
  logic  badIdx;
  logic  illegal;

  assign cond = cond_e'(condCode);

  always_comb begin
    unique case (cond)
      CC_EQUAL:   condMet = flagZ;
      CC_OVFL:    condMet = flagV;
      CC_GEQ:     condMet = (flagN == flagV);
      CC_GREATER: condMet = !flagZ && (flagN == flagV);
      default:    condMet = 1'b0;
    endcase
  end

  assign highIdx = idxD[BANK_BIT] | idxN[BANK_BIT] | idxM[BANK_BIT];

  generate
    if (HAS_UPPER_BANK) begin : g_fullBank
      assign badIdx = 1'b0;
    end else begin : g_halfBank
      assign badIdx = isDouble && highIdx;
    end
  endgenerate

  generate
    if (HAS_SEL) begin : g_selPresent
      assign illegal = badIdx;
    end else begin : g_selAbsent
      assign illegal = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.load      = reqValid && !illegal;
    strobe.pickFirst = condMet;
    strobe.narrow    = !isDouble;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) undefFlag <= 1'b0;
    else        undefFlag <= reqValid && illegal;
  end

endmodule

// File: rtl/fcsel_datapath.sv
module fcsel_datapath
  import fcsel_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_strobe_t       strobe,
  input  logic [DATA_W-1:0] opN,
  input  logic [DATA_W-1:0] opM,
  input  logic [IDX_W-1:0]  idxD,
  output logic [DATA_W-1:0] resData,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrEn
);

  localparam int UPPER_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] chosen;
  logic [DATA_W-1:0] shaped;

  assign chosen = strobe.pickFirst ? opN : opM;

  generate
    if (UPPER_W > 0) begin : g_widen
      assign shaped = strobe.narrow
                    ? {{UPPER_W{1'b0}}, chosen[NARROW_W-1:0]}
                    : chosen;
    end else begin : g_same
      assign shaped = chosen;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resData <= '0;
      wrIdx   <= '0;
      wrEn    <= 1'b0;
    end else begin
      wrEn <= strobe.load;
      if (strobe.load) begin
        resData <= shaped;
        wrIdx   <= idxD;
      end
    end
  end

endmodule

// File: rtl/fp_cond_select.sv
module fp_cond_select
  import fcsel_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int NARROW_W       = 32,
  parameter int IDX_W          = 5,
  parameter bit HAS_SEL        = 1'b1,
  parameter bit HAS_UPPER_BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              isDouble,
  input  logic [1:0]        condCode,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic [IDX_W-1:0]  idxD,
  input  logic [IDX_W-1:0]  idxN,
  input  logic [IDX_W-1:0]  idxM,
  input  logic [DATA_W-1:0] opN,
  input  logic [DATA_W-1:0] opM,
  output logic [DATA_W-1:0] resData,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrEn,
  output logic              undefFlag
);

  sel_strobe_t strobe;

  fcsel_ctrl #(
    .IDX_W(IDX_W),
    .HAS_SEL(HAS_SEL),
    .HAS_UPPER_BANK(HAS_UPPER_BANK)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isDouble(isDouble),
    .condCode(condCode), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .idxD(idxD), .idxN(idxN), .idxM(idxM),
    .strobe(strobe), .undefFlag(undefFlag)
  );

  fcsel_datapath #(
    .DATA_W(DATA_W),
    .NARROW_W(NARROW_W),
    .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opN(opN), .opM(opM),
    .idxD(idxD), .resData(resData), .wrIdx(wrIdx), .wrEn(wrEn)
  );

endmodule

// File: rtl/fcsel_chk.sv
module fcsel_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 5,
  parameter bit HAS_SEL  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              isDouble,
  input logic [IDX_W-1:0]  idxD,
  input logic [DATA_W-1:0] resData,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrEn,
  input logic              undefFlag
);

  // R7
  undef_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(undefFlag && wrEn));

  // R11
  pulse_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn || undefFlag) |-> $past(reqValid));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> $stable(resData));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !$past(isDouble)) |-> (resData[DATA_W-1:NARROW_W] == '0));

  // R12
  dest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (wrIdx == $past(idxD)));

  // R10
  absent_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> HAS_SEL);

endmodule

bind fp_cond_select fcsel_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W), .HAS_SEL(HAS_SEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isDouble(isDouble),
  .idxD(idxD), .resData(resData), .wrIdx(wrIdx), .wrEn(wrEn),
  .undefFlag(undefFlag)
);

// File: tb/tb_fp_cond_select.sv
`timescale 1ns/1ps
module tb_fp_cond_select;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        isDouble = 1'b0;
  logic [1:0]  condCode = 2'd0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0;
  logic [4:0]  idxD = '0, idxN = '0, idxM = '0;
  logic [63:0] opN = '0, opM = '0;

  logic [63:0] res0, res1, res2;
  logic [4:0]  wi0, wi1, wi2;
  logic        we0, we1, we2, un0, un1, un2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] heldRes [3];
  logic [4:0]  heldIdx [3];

  always #10 clk = ~clk;

  fp_cond_select dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isDouble(isDouble),
    .condCode(condCode), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .idxD(idxD), .idxN(idxN), .idxM(idxM), .opN(opN), .opM(opM),
    .resData(res0), .wrIdx(wi0), .wrEn(we0), .undefFlag(un0));

  fp_cond_select #(.HAS_UPPER_BANK(1'b1)) dutWide (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isDouble(isDouble),
    .condCode(condCode), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .idxD(idxD), .idxN(idxN), .idxM(idxM), .opN(opN), .opM(opM),
    .resData(res1), .wrIdx(wi1), .wrEn(we1), .undefFlag(un1));

  fp_cond_select #(.HAS_SEL(1'b0)) dutNoSel (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isDouble(isDouble),
    .condCode(condCode), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .idxD(idxD), .idxN(idxN), .idxM(idxM), .opN(opN), .opM(opM),
    .resData(res2), .wrIdx(wi2), .wrEn(we2), .undefFlag(un2));

  function automatic bit condHolds(input logic [1:0] cc, input bit n, input bit z, input bit v);
    case (cc)
      2'd0: return z;
      2'd1: return v;
      2'd2: return n == v;
      default: return !z && (n == v);
    endcase
  endfunction

  function automatic string condTag(input logic [1:0] cc, input bit dbl);
    if (!dbl) return "R6";
    case (cc)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkInst(input int k, input bit expUndef, input string undefTag,
                           input string dataTag);
    logic [63:0] r; logic [4:0] wi; logic we, un;
    case (k)
      0: begin r = res0; wi = wi0; we = we0; un = un0; end
      1: begin r = res1; wi = wi1; we = we1; un = un1; end
      default: begin r = res2; wi = wi2; we = we2; un = un2; end
    endcase
    check(un == expUndef, undefTag, $sformatf("inst%0d undefFlag", k), 64'(un), 64'(expUndef));
    check(we == !expUndef, "R11", $sformatf("inst%0d wrEn", k), 64'(we), 64'(!expUndef));
    check(r == heldRes[k], expUndef ? undefTag : dataTag,
          $sformatf("inst%0d resData", k), r, heldRes[k]);
    check(wi == heldIdx[k], "R12", $sformatf("inst%0d wrIdx", k), 64'(wi), 64'(heldIdx[k]));
  endtask

  task automatic runReq(input bit dbl, input logic [1:0] cc, input bit n, input bit z,
                        input bit v, input logic [4:0] d, input logic [4:0] a,
                        input logic [4:0] b, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] pick;
    bit hi;
    bit und [3];
    @(negedge clk);
    reqValid = 1'b1; isDouble = dbl; condCode = cc; flagN = n; flagZ = z; flagV = v;
    idxD = d; idxN = a; idxM = b; opN = x; opM = y;
    pick = condHolds(cc, n, z, v) ? x : y;
    if (!dbl) pick[63:32] = '0;
    hi = d[4] | a[4] | b[4];
    und[0] = dbl && hi;
    und[1] = 1'b0;
    und[2] = 1'b1;
    for (int k = 0; k < 3; k++)
      if (!und[k]) begin heldRes[k] = pick; heldIdx[k] = d; end
    @(negedge clk);
    reqValid = 1'b0;
    checkInst(0, und[0], dbl ? "R7" : "R8", condTag(cc, dbl));
    checkInst(1, und[1], "R9", condTag(cc, dbl));
    checkInst(2, und[2], "R10", "R10");
  endtask

  task automatic idleCheck();
    @(negedge clk);
    @(negedge clk);
    check(!we0 && !un0 && !we1 && !un1 && !we2 && !un2, "R11", "idle pulses",
          64'({we0, un0, we1, un1, we2, un2}), 64'd0);
    check(res0 == heldRes[0] && res1 == heldRes[1], "R11", "idle hold",
          res0, heldRes[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int k = 0; k < 3; k++) begin heldRes[k] = '0; heldIdx[k] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res0 == 0 && !we0 && !un0, "R1", "reset outputs",
          {res0[61:0], we0, un0}, 64'd0);
    check(res1 == 0 && res2 == 0 && !we2 && !un2, "R1", "reset outputs other",
          res1 | res2, 64'd0);
    rst_n = 1'b1;
    idleCheck();

    // directed corners: R5 gt, R4 ge, R2 eq, R3 vs
    runReq(1, 2'd3, 0, 1, 0, 5'd1, 5'd2, 5'd3, 64'hAAAA_0000_1111_2222, 64'h5555_3333_4444_6666);
    runReq(1, 2'd3, 1, 0, 0, 5'd1, 5'd2, 5'd3, 64'hAAAA_0000_1111_2222, 64'h5555_3333_4444_6666);
    runReq(1, 2'd3, 1, 0, 1, 5'd4, 5'd2, 5'd3, 64'hAAAA_0000_1111_2222, 64'h5555_3333_4444_6666);
    runReq(1, 2'd2, 1, 0, 1, 5'd6, 5'd7, 5'd8, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    runReq(1, 2'd0, 0, 1, 0, 5'd9, 5'd0, 5'd0, 64'h1, 64'h2);
    runReq(1, 2'd1, 0, 0, 1, 5'd9, 5'd0, 5'd0, 64'h3, 64'h4);
    // R6 narrow, R8 high index single
    runReq(0, 2'd0, 0, 1, 0, 5'd31, 5'd30, 5'd17, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0);
    // R7 / R9 high index double
    runReq(1, 2'd0, 0, 1, 0, 5'd16, 5'd0, 5'd0, 64'hCAFE, 64'hF00D);
    runReq(1, 2'd2, 0, 0, 0, 5'd2, 5'd0, 5'd20, 64'hBEEF, 64'hFACE);
    idleCheck();

    for (int i = 0; i < 400; i++) begin
      runReq($urandom % 2, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             5'($urandom), 5'($urandom), 5'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom});
      if (i % 50 == 0) idleCheck();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule